// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

This block guards an embedded controller against a stalled program. Software arms it by writing a one to its enable bit. After that, software has no way to turn it off again. The bit is cleared only by a synchronous system reset or by the watchdog's own timeout.

While the watchdog is armed, a machine-cycle divider feeds an 11-bit prescaler. Each time the prescaler wraps, an 8-bit counter advances by one. Software has to reload that counter with an 8-bit start value often enough to keep it from rolling past its top value. The start value sets the time left before a timeout. A larger start value leaves less time. When the counter rolls over, the block issues a one-cycle reset request and returns to its idle state.

With the default parameters (divide-by-6 machine cycle, 11-bit prescaler) the counter advances every 12288 clocks. At 16 MHz this is 0.768 ms.

Top module: `wdog_timer`

## Requirements
- R1: After the asynchronous reset, `armed_o`, `count_o` and `rst_req_o` are all zero.
- R2: While disarmed, `count_o` never advances and `rst_req_o` stays low. A reload while disarmed still loads `count_o`.
- R3: A write with `arm_we_i`=1 and `arm_wdata_i`=1 sets `armed_o` on the next clock edge.
- R4: A write with `arm_wdata_i`=0 has no effect. `armed_o` stays set until `sync_rst_i` or a timeout clears it.
- R5: While armed, `count_o` advances by one every MC_DIV·2^PRE_W clocks.
- R6: Reloading value N while armed produces a `rst_req_o` pulse exactly (256−N)·MC_DIV·2^PRE_W clocks after the reload edge. The pulse lasts exactly one cycle.
- R7: In the cycle in which `rst_req_o` is high, `armed_o` and `count_o` are already zero.
- R8: A reload applied on the very edge at which the counter would roll over wins. No request is issued, and `count_o` takes the reload value.
- R9: `sync_rst_i` clears `armed_o`, `count_o` and the prescaler on the next edge. It has priority over every other input.
- R10: A reload also clears the machine divider and the prescaler. The next advance therefore comes a full period after the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous system reset; the only way to disarm from software's side |
| arm_we_i | input | 1 | Write strobe for the enable bit |
| arm_wdata_i | input | 1 | Value written to the enable bit; only a one takes effect |
| reload_i | input | 1 | Reload strobe |
| reload_val_i | input | CNT_W (8) | Counter start value |
| armed_o | output | 1 | Enable bit |
| count_o | output | CNT_W (8) | Current counter value |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two events can fall in the same cycle: a software reload and the counter's rollover. The bench reloads 0xFF and counts clocks until the edge that would carry the rollover. It then drives a new reload so that it lands on exactly that edge. The result is judged at the ports: `rst_req_o` must stay low, `armed_o` must stay high, and `count_o` must hold the new value. A second race, a reload arriving just a few cycles into a period, shows that the period restarts from the reload edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_MC_DIV = 6;
  localparam int unsigned WD_PRE_W  = 11;
  localparam int unsigned WD_CNT_W  = 8;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_LOAD  = 2'd1,
    CNT_STEP  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int unsigned MOD = 6,
  localparam int unsigned W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = (cnt_q == W'(MOD - 1));
  assign tick_o = en_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_arm.sv
module wdog_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wipe_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic armed_o
);
  logic armed_q;

  // a zero write is dropped: only wipe disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (wipe_i)            armed_q <= 1'b0;
    else if (we_i && wdata_i)   armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = WD_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (op_i)
        CNT_LOAD:  cnt_q <= load_i;
        CNT_STEP:  cnt_q <= cnt_q + 1'b1;
        CNT_CLEAR: cnt_q <= '0;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned MC_DIV = WD_MC_DIV,
  parameter int unsigned PRE_W  = WD_PRE_W,
  parameter int unsigned CNT_W  = WD_CNT_W,
  localparam int unsigned PRE_MOD = 1 << PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_rst_i,
  input  logic             arm_we_i,
  input  logic             arm_wdata_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  logic    armed;
  logic    mc_tick;
  logic    pre_tick;
  logic    at_max;
  logic    ovf_evt;
  logic    wipe;
  logic    stage_clr;
  logic    rst_req_q;
  cnt_op_e cnt_op;

  // reload on the rollover edge beats the timeout
  assign ovf_evt   = armed & pre_tick & at_max & ~reload_i & ~sync_rst_i;
  assign wipe      = sync_rst_i | ovf_evt;
  assign stage_clr = wipe | reload_i | ~armed;

  generate
    if (MC_DIV > 1) begin : g_mc_div
      wdog_stage #(.MOD(MC_DIV)) u_mc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (stage_clr),
        .en_i   (armed),
        .tick_o (mc_tick)
      );
    end else begin : g_mc_pass
      assign mc_tick = armed;
    end
  endgenerate

  wdog_stage #(.MOD(PRE_MOD)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stage_clr),
    .en_i   (mc_tick),
    .tick_o (pre_tick)
  );

  wdog_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wipe_i  (wipe),
    .we_i    (arm_we_i),
    .wdata_i (arm_wdata_i),
    .armed_o (armed)
  );

  always_comb begin
    if (wipe)                   cnt_op = CNT_CLEAR;
    else if (reload_i)          cnt_op = CNT_LOAD;
    else if (armed && pre_tick) cnt_op = CNT_STEP;
    else                        cnt_op = CNT_HOLD;
  end

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (cnt_op),
    .load_i   (reload_val_i),
    .cnt_o    (count_o),
    .at_max_o (at_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= ovf_evt;
  end

  assign armed_o   = armed;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_rst_i,
  input logic             reload_i,
  input logic             armed_o,
  input logic [CNT_W-1:0] count_o,
  input logic             rst_req_o
);
  a_r6_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r7_req_idle_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (!armed_o && count_o == '0));

  a_r6_req_from_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(armed_o));

  a_r4_sticky_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !sync_rst_i) |=> (armed_o || rst_req_o));

  a_r9_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (!armed_o && count_o == '0 && !rst_req_o));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !reload_i && !sync_rst_i) |=> ($stable(count_o) && !rst_req_o));

  a_r8_reload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !rst_req_o);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_rst_i (sync_rst_i),
  .reload_i   (reload_i),
  .armed_o    (armed_o),
  .count_o    (count_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int unsigned MC_DIV = 3;
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned T      = MC_DIV * (1 << PRE_W);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_rst = 1'b0;
  logic             arm_we = 1'b0;
  logic             arm_wdata = 1'b0;
  logic             reload = 1'b0;
  logic [CNT_W-1:0] reload_val = '0;
  logic             armed;
  logic [CNT_W-1:0] count;
  logic             rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdog_timer #(.MC_DIV(MC_DIV), .PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_rst_i   (sync_rst),
    .arm_we_i     (arm_we),
    .arm_wdata_i  (arm_wdata),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .armed_o      (armed),
    .count_o      (count),
    .rst_req_o    (rst_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_arm(input logic val);
    arm_we = 1'b1; arm_wdata = val;
    @(negedge clk);
    arm_we = 1'b0; arm_wdata = 1'b0;
  endtask

  task automatic do_reload(input logic [CNT_W-1:0] v);
    reload = 1'b1; reload_val = v;
    @(negedge clk);
    reload = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "armed", armed, 0);
    chk("R1", "count", count, 0);
    chk("R1", "req", rst_req, 0);
  endtask

  task automatic t_idle;
    do_reload(8'h10);
    chk("R2", "load while idle", count, 8'h10);
    wait_cyc(3 * T);
    chk("R2", "no advance", count, 8'h10);
    chk("R2", "no req", rst_req, 0);
  endtask

  task automatic t_arm;
    do_arm(1'b1);
    chk("R3", "armed", armed, 1);
  endtask

  task automatic t_write0;
    do_arm(1'b0);
    chk("R4", "armed after 0 write", armed, 1);
    wait_cyc(2);
    chk("R4", "still armed", armed, 1);
  endtask

  task automatic t_step;
    do_reload(8'h40);
    wait_cyc(T - 1);
    chk("R5", "before first step", count, 8'h40);
    wait_cyc(1);
    chk("R5", "first step", count, 8'h41);
    wait_cyc(T);
    chk("R5", "second step", count, 8'h42);
  endtask

  task automatic t_timeout;
    do_reload(8'hFD);
    wait_cyc(3 * T - 1);
    chk("R6", "req before timeout", rst_req, 0);
    chk("R6", "count at top", count, 8'hFF);
    wait_cyc(1);
    chk("R6", "req at timeout", rst_req, 1);
    chk("R7", "armed in req cycle", armed, 0);
    chk("R7", "count in req cycle", count, 0);
    wait_cyc(1);
    chk("R6", "req one cycle", rst_req, 0);
  endtask

  task automatic t_restart;
    do_arm(1'b1);
    do_reload(8'h20);
    wait_cyc(5);
    do_reload(8'h20);
    wait_cyc(T - 1);
    chk("R10", "period restarted", count, 8'h20);
    wait_cyc(1);
    chk("R10", "step after full period", count, 8'h21);
  endtask

  task automatic t_race;
    do_reload(8'hFF);
    wait_cyc(T - 1);
    do_reload(8'hFF);
    chk("R8", "no req on race", rst_req, 0);
    chk("R8", "still armed", armed, 1);
    chk("R8", "reload value kept", count, 8'hFF);
    wait_cyc(1);
    chk("R8", "no late req", rst_req, 0);
  endtask

  task automatic t_sync;
    do_reload(8'h80);
    sync_rst = 1'b1; arm_we = 1'b1; arm_wdata = 1'b1;
    @(negedge clk);
    sync_rst = 1'b0; arm_we = 1'b0; arm_wdata = 1'b0;
    chk("R9", "armed cleared", armed, 0);
    chk("R9", "count cleared", count, 0);
    wait_cyc(2 * T);
    chk("R9", "stays idle", count, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_arm();
    t_write0();
    t_step();
    t_timeout();
    t_restart();
    t_race();
    t_sync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule